// File: doc/BRIEF.md
# Exclusive Halfword Store Unit

This unit carries out a conditional halfword store with release ordering against a small local reservation monitor. It takes one decoded 32-bit instruction word, reads a base register and a data register through a combinational register-file read interface, and writes through a single-port memory write interface. The store goes ahead only when a reservation made earlier covers the target 2-byte range. The unit writes a zero-extended 32-bit pass/fail word back to a status register. A misaligned stack pointer or a misaligned address whose check passes raises an abort, and an abort blocks every write.

A load-exclusive hook (`ldx_i` with an address) sets the reservation so the unit can be used on its own. Each operation waits until the core reports that no earlier accesses are pending. It then takes one check cycle and one commit cycle, and marks the commit cycle with a done pulse. Two parameters choose how the unit handles register overlaps: status index equal to data index, and status index equal to base index. Each parameter selects one of four policies.

Top module: `excl_hword_store`

## Requirements
- R1: An instruction is legal only if bits [31:21] equal 01001000000 and bit 15 is 1. The status index is in [20:16], the base index in [9:5] and the data index in [4:0]. An illegal word gives `undef_o` at commit with no memory write, no status write and an unchanged reservation. Bits [14:10] have no effect.
- R2: A one-cycle `ldx_i` pulse records `ldx_addr_i` as the reservation and marks it valid.
- R3: The check passes when the reservation is valid and matches the store address with bit 0 ignored. A passing, aligned store writes the low 16 bits of the data register at the store address and writes status value 0. A data index of 31 reads as zero.
- R4: A failing check performs no memory write. It writes status value 1, zero-extended to 32 bits, to the status index.
- R5: Every operation that reaches the monitor check clears the reservation, whether it succeeds, fails or aborts. Undefined and no-op outcomes leave the reservation as it was.
- R6: Base index 31 takes its address from `sp_i`. If the low 4 bits of `sp_i` are not zero, `abort_sp_o` is raised whatever the reservation state.
- R7: An odd address with a passing check raises `abort_align_o`. An odd address with a failing check raises no abort and writes status 1.
- R8: While either abort is raised, neither `mem_we_o` nor `rf_we_o` is asserted.
- R9: Status index equal to data index applies `DATA_OVL`. Policy 0 stores `UNK_DATA`. Policy 1 stores the register value. Policy 2 raises `undef_o`. Policy 3 completes with no effect at all.
- R10: Status index equal to base index, with base index not 31, applies `BASE_OVL` with the same codes, except that policy 0 uses `UNK_ADDR` as the address. The data overlap is resolved before the base overlap.
- R11: `start_i` is accepted only while `busy_o` is low. The unit waits while `pend_empty_i` is low, then spends one check cycle and one commit cycle. `done_o` is high for exactly the commit cycle. With no stall, `done_o` is high in the third cycle after acceptance.
- R12: The status write uses the status field as `rf_waddr_o`, including index 31. Address and data outputs read zero when their write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation with `insn_i` |
| insn_i | input | 32 | Instruction word |
| pend_empty_i | input | 1 | No earlier memory accesses outstanding |
| ldx_i | input | 1 | Load-exclusive reservation set |
| ldx_addr_i | input | AW | Address to reserve |
| sp_i | input | AW | Stack pointer value |
| rf_base_idx_o | output | 5 | Base register read index |
| rf_base_i | input | AW | Base register value |
| rf_data_idx_o | output | 5 | Data register read index |
| rf_data_i | input | 16 | Low halfword of the data register |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Byte address of the halfword |
| mem_wdata_o | output | 16 | Halfword written |
| rf_we_o | output | 1 | Status register write strobe |
| rf_waddr_o | output | 5 | Status register index |
| rf_wdata_o | output | 32 | Status word |
| abort_align_o | output | 1 | Alignment abort |
| abort_sp_o | output | 1 | Stack pointer alignment abort |
| undef_o | output | 1 | Undefined instruction |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Commit cycle |

## Verification
The bench builds two copies side by side and drives both with the same stimulus. The first copy uses policy 0 for both overlaps, so substituted data (`UNK_DATA` = 0xBEEF) and a substituted address (`UNK_ADDR` = 0x5000) both show at the memory port. The second copy uses no-op for the data overlap and undefined for the base overlap. That setting lets the bench show that a no-op keeps the reservation, because a later store passes on one copy and fails on the other. It also shows that the data overlap takes precedence when all three indices match.

// File: rtl/exs_pkg.sv
package exs_pkg;
  typedef enum logic [1:0] {
    OVL_UNKNOWN = 2'd0,
    OVL_KEEP    = 2'd1,
    OVL_UNDEF   = 2'd2,
    OVL_NOP     = 2'd3
  } ovl_policy_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ORDER,
    ST_CHECK,
    ST_COMMIT
  } exs_state_e;

  typedef struct packed {
    logic undef;
    logic nop;
    logic unk;
  } ovl_res_t;

  localparam logic [10:0] OPC_HI   = 11'b01001000000;
  localparam int unsigned IDX_W    = 5;
  localparam logic [4:0]  IDX_SP   = 5'd31;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned STATUS_W = 32;
endpackage

// File: rtl/exs_ovl_res.sv
module exs_ovl_res
  import exs_pkg::*;
#(
  parameter ovl_policy_e POLICY = OVL_KEEP
) (
  input  logic     hit_i,
  output ovl_res_t res_o
);
  generate
    if (POLICY == OVL_UNKNOWN) begin : g_unk
      assign res_o = '{undef: 1'b0, nop: 1'b0, unk: hit_i};
    end else if (POLICY == OVL_UNDEF) begin : g_undef
      assign res_o = '{undef: hit_i, nop: 1'b0, unk: 1'b0};
    end else if (POLICY == OVL_NOP) begin : g_nop
      assign res_o = '{undef: 1'b0, nop: hit_i, unk: 1'b0};
    end else begin : g_keep
      assign res_o = '{undef: 1'b0, nop: 1'b0, unk: 1'b0};
    end
  endgenerate
endmodule

// File: rtl/exs_decode.sv
module exs_decode
  import exs_pkg::*;
#(
  parameter ovl_policy_e DATA_OVL = OVL_KEEP,
  parameter ovl_policy_e BASE_OVL = OVL_KEEP
) (
  input  logic [10:0]      opc_i,
  input  logic             b15_i,
  input  logic [IDX_W-1:0] s_idx_i,
  input  logic [IDX_W-1:0] n_idx_i,
  input  logic [IDX_W-1:0] t_idx_i,
  output logic             legal_o,
  output logic             base_sp_o,
  output ovl_res_t         data_res_o,
  output ovl_res_t         base_res_o
);
  logic data_hit, base_hit;

  assign legal_o   = (opc_i == OPC_HI) && b15_i;
  assign base_sp_o = (n_idx_i == IDX_SP);
  assign data_hit  = (s_idx_i == t_idx_i);
  assign base_hit  = (s_idx_i == n_idx_i) && !base_sp_o;

  exs_ovl_res #(.POLICY(DATA_OVL)) i_data_ovl (
    .hit_i (data_hit),
    .res_o (data_res_o)
  );

  exs_ovl_res #(.POLICY(BASE_OVL)) i_base_ovl (
    .hit_i (base_hit),
    .res_o (base_res_o)
  );
endmodule

// File: rtl/exs_monitor.sv
module exs_monitor #(
  parameter int unsigned AW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [AW-1:0] set_addr_i,
  input  logic          clr_i,
  input  logic [AW-1:0] chk_addr_i,
  output logic          valid_o,
  output logic          pass_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;

  // a new reservation wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      addr_q  <= set_addr_i;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign pass_o  = valid_q && (addr_q[AW-1:1] == chk_addr_i[AW-1:1]);

  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> valid_q && (addr_q == $past(set_addr_i)));
endmodule

// File: rtl/exs_ctrl.sv
module exs_ctrl
  import exs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pend_empty_i,
  output logic accept_o,
  output logic check_o,
  output logic commit_o,
  output logic busy_o
);
  exs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_ORDER;
      ST_ORDER:  if (pend_empty_i) state_d = ST_CHECK;
      ST_CHECK:  state_d = ST_COMMIT;
      ST_COMMIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign check_o  = (state_q == ST_CHECK);
  assign commit_o = (state_q == ST_COMMIT);
  assign busy_o   = (state_q != ST_IDLE);

  assert_commit_follows_check_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_o |=> commit_o);
endmodule

// File: rtl/excl_hword_store.sv
module excl_hword_store
  import exs_pkg::*;
#(
  parameter int unsigned AW       = 64,
  parameter int unsigned SP_ALIGN = 4,
  parameter ovl_policy_e DATA_OVL = OVL_KEEP,
  parameter ovl_policy_e BASE_OVL = OVL_KEEP,
  parameter logic [15:0] UNK_DATA = 16'h0000,
  parameter logic [AW-1:0] UNK_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [31:0]   insn_i,
  input  logic          pend_empty_i,
  input  logic          ldx_i,
  input  logic [AW-1:0] ldx_addr_i,
  input  logic [AW-1:0] sp_i,
  output logic [4:0]    rf_base_idx_o,
  input  logic [AW-1:0] rf_base_i,
  output logic [4:0]    rf_data_idx_o,
  input  logic [15:0]   rf_data_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  output logic          rf_we_o,
  output logic [4:0]    rf_waddr_o,
  output logic [31:0]   rf_wdata_o,
  output logic          abort_align_o,
  output logic          abort_sp_o,
  output logic          undef_o,
  output logic          busy_o,
  output logic          done_o
);
  logic accept, check, commit;

  // latched instruction fields; bits [14:10] are not retained
  logic [10:0]      opc_q;
  logic             b15_q;
  logic [IDX_W-1:0] s_q, n_q, t_q;
  logic             sbo_unused;
  assign sbo_unused = ^insn_i[14:10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q <= '0;
      b15_q <= 1'b0;
      s_q   <= '0;
      n_q   <= '0;
      t_q   <= '0;
    end else if (accept) begin
      opc_q <= insn_i[31:21];
      b15_q <= insn_i[15];
      s_q   <= insn_i[20:16];
      n_q   <= insn_i[9:5];
      t_q   <= insn_i[4:0];
    end
  end

  exs_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .pend_empty_i (pend_empty_i),
    .accept_o     (accept),
    .check_o      (check),
    .commit_o     (commit),
    .busy_o       (busy_o)
  );

  logic     legal, base_sp;
  ovl_res_t data_res, base_res;

  exs_decode #(.DATA_OVL(DATA_OVL), .BASE_OVL(BASE_OVL)) i_decode (
    .opc_i      (opc_q),
    .b15_i      (b15_q),
    .s_idx_i    (s_q),
    .n_idx_i    (n_q),
    .t_idx_i    (t_q),
    .legal_o    (legal),
    .base_sp_o  (base_sp),
    .data_res_o (data_res),
    .base_res_o (base_res)
  );

  assign rf_base_idx_o = n_q;
  assign rf_data_idx_o = t_q;

  logic [AW-1:0] addr_c;
  logic [15:0]   data_c;
  logic          sp_bad;

  always_comb begin
    if (base_res.unk)  addr_c = UNK_ADDR;
    else if (base_sp)  addr_c = sp_i;
    else               addr_c = rf_base_i;
    data_c = data_res.unk ? UNK_DATA : rf_data_i;
    sp_bad = base_sp && (sp_i[SP_ALIGN-1:0] != '0);
  end

  logic mon_valid, mon_pass, mon_clr;

  // outcome of the check cycle
  logic c_mem_we, c_rf_we, c_status, c_ab_al, c_ab_sp, c_undef, c_clr;

  always_comb begin
    c_mem_we = 1'b0;
    c_rf_we  = 1'b0;
    c_status = 1'b1;
    c_ab_al  = 1'b0;
    c_ab_sp  = 1'b0;
    c_undef  = 1'b0;
    c_clr    = 1'b0;
    if (!legal || data_res.undef) begin
      c_undef = 1'b1;
    end else if (data_res.nop) begin
      c_undef = 1'b0;
    end else if (base_res.undef) begin
      c_undef = 1'b1;
    end else if (base_res.nop) begin
      c_undef = 1'b0;
    end else begin
      c_clr = 1'b1;
      if (sp_bad) begin
        c_ab_sp = 1'b1;
      end else if (mon_pass && addr_c[0]) begin
        c_ab_al = 1'b1;
      end else if (mon_pass) begin
        c_mem_we = 1'b1;
        c_rf_we  = 1'b1;
        c_status = 1'b0;
      end else begin
        c_rf_we  = 1'b1;
      end
    end
  end

  logic          r_mem_we, r_rf_we, r_status, r_ab_al, r_ab_sp, r_undef, r_clr;
  logic [AW-1:0] r_addr;
  logic [15:0]   r_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_mem_we <= 1'b0;
      r_rf_we  <= 1'b0;
      r_status <= 1'b0;
      r_ab_al  <= 1'b0;
      r_ab_sp  <= 1'b0;
      r_undef  <= 1'b0;
      r_clr    <= 1'b0;
      r_addr   <= '0;
      r_data   <= '0;
    end else if (check) begin
      r_mem_we <= c_mem_we;
      r_rf_we  <= c_rf_we;
      r_status <= c_status;
      r_ab_al  <= c_ab_al;
      r_ab_sp  <= c_ab_sp;
      r_undef  <= c_undef;
      r_clr    <= c_clr;
      r_addr   <= addr_c;
      r_data   <= data_c;
    end
  end

  assign mon_clr = commit && r_clr;

  exs_monitor #(.AW(AW)) i_monitor (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (ldx_i),
    .set_addr_i (ldx_addr_i),
    .clr_i      (mon_clr),
    .chk_addr_i (addr_c),
    .valid_o    (mon_valid),
    .pass_o     (mon_pass)
  );

  assign done_o        = commit;
  assign mem_we_o      = commit && r_mem_we;
  assign mem_addr_o    = mem_we_o ? r_addr : '0;
  assign mem_wdata_o   = mem_we_o ? r_data : '0;
  assign rf_we_o       = commit && r_rf_we;
  assign rf_waddr_o    = rf_we_o ? s_q : '0;
  assign rf_wdata_o    = rf_we_o ? {{(STATUS_W-1){1'b0}}, r_status} : '0;
  assign abort_align_o = commit && r_ab_al;
  assign abort_sp_o    = commit && r_ab_sp;
  assign undef_o       = commit && r_undef;

  assert_abort_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_align_o || abort_sp_o) |-> !mem_we_o && !rf_we_o);
  assert_undef_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> !mem_we_o && !rf_we_o && !abort_align_o && !abort_sp_o);
  assert_status_zext_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_wdata_o[31:1] == '0));
  assert_store_status_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> rf_we_o && !rf_wdata_o[0]);
  assert_store_reserved_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mon_valid);
  assert_store_aligned_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !mem_addr_o[0]);
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_one_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(abort_sp_o && abort_align_o));
endmodule

// File: tb/test_excl_hword_store.sv
module test_excl_hword_store;
  import exs_pkg::*;

  localparam logic [15:0] UD = 16'hBEEF;
  localparam logic [63:0] UA = 64'h5000;

  typedef struct packed {
    logic        mem_we;
    logic [63:0] addr;
    logic [15:0] wdata;
    logic        rf_we;
    logic [4:0]  waddr;
    logic [31:0] status;
    logic        ab_al;
    logic        ab_sp;
    logic        undef;
  } obs_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] insn = '0;
  logic        pend = 1'b1;
  logic        ldx = 1'b0;
  logic [63:0] ldx_addr = '0;
  logic [63:0] sp = '0;
  logic [63:0] regs [32];

  always #2.5 clk = ~clk;

  logic [4:0]  bidx_a, didx_a, bidx_b, didx_b, wa_a, wa_b;
  logic [63:0] ma_a, ma_b;
  logic [15:0] md_a, md_b;
  logic [31:0] wd_a, wd_b;
  logic we_a, we_b, rwe_a, rwe_b, al_a, al_b, spab_a, spab_b, ud_a, ud_b, busy_a, busy_b, done_a, done_b;

  excl_hword_store #(.AW(64), .DATA_OVL(OVL_UNKNOWN), .BASE_OVL(OVL_UNKNOWN),
                     .UNK_DATA(UD), .UNK_ADDR(UA)) i_excl_hword_store (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .insn_i(insn), .pend_empty_i(pend),
    .ldx_i(ldx), .ldx_addr_i(ldx_addr), .sp_i(sp),
    .rf_base_idx_o(bidx_a), .rf_base_i(regs[bidx_a]),
    .rf_data_idx_o(didx_a), .rf_data_i(didx_a == 5'd31 ? 16'h0 : regs[didx_a][15:0]),
    .mem_we_o(we_a), .mem_addr_o(ma_a), .mem_wdata_o(md_a),
    .rf_we_o(rwe_a), .rf_waddr_o(wa_a), .rf_wdata_o(wd_a),
    .abort_align_o(al_a), .abort_sp_o(spab_a), .undef_o(ud_a), .busy_o(busy_a), .done_o(done_a));

  excl_hword_store #(.AW(64), .DATA_OVL(OVL_NOP), .BASE_OVL(OVL_UNDEF),
                     .UNK_DATA(UD), .UNK_ADDR(UA)) i_excl_hword_store_b (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .insn_i(insn), .pend_empty_i(pend),
    .ldx_i(ldx), .ldx_addr_i(ldx_addr), .sp_i(sp),
    .rf_base_idx_o(bidx_b), .rf_base_i(regs[bidx_b]),
    .rf_data_idx_o(didx_b), .rf_data_i(didx_b == 5'd31 ? 16'h0 : regs[didx_b][15:0]),
    .mem_we_o(we_b), .mem_addr_o(ma_b), .mem_wdata_o(md_b),
    .rf_we_o(rwe_b), .rf_waddr_o(wa_b), .rf_wdata_o(wd_b),
    .abort_align_o(al_b), .abort_sp_o(spab_b), .undef_o(ud_b), .busy_o(busy_b), .done_o(done_b));

  obs_t act_a, act_b;
  assign act_a = '{we_a, ma_a, md_a, rwe_a, wa_a, wd_a, al_a, spab_a, ud_a};
  assign act_b = '{we_b, ma_b, md_b, rwe_b, wa_b, wd_b, al_b, spab_b, ud_b};

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic        rv [2];
  logic [63:0] ra [2];

  task automatic chk(input logic [127:0] a, input logic [127:0] e, input string tag);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input logic [4:0] s, input logic [4:0] n, input logic [4:0] t);
    return {11'b01001000000, s, 1'b1, 5'b11111, n, t};
  endfunction

  task automatic predict(input int k, input logic [31:0] w, output obs_t e);
    ovl_policy_e pd, pb;
    logic [4:0]  s, n, t;
    logic        dh, bh, pass;
    logic [63:0] a;
    logic [15:0] d;
    pd = (k == 0) ? OVL_UNKNOWN : OVL_NOP;
    pb = (k == 0) ? OVL_UNKNOWN : OVL_UNDEF;
    e = '0;
    s = w[20:16]; n = w[9:5]; t = w[4:0];
    if (w[31:21] != 11'b01001000000 || !w[15]) begin e.undef = 1'b1; return; end
    dh = (s == t);
    bh = (s == n) && (n != 5'd31);
    if (dh && pd == OVL_UNDEF) begin e.undef = 1'b1; return; end
    if (dh && pd == OVL_NOP) return;
    if (bh && pb == OVL_UNDEF) begin e.undef = 1'b1; return; end
    if (bh && pb == OVL_NOP) return;
    a = (n == 5'd31) ? sp : regs[n];
    if (bh && pb == OVL_UNKNOWN) a = UA;
    d = (t == 5'd31) ? 16'h0 : regs[t][15:0];
    if (dh && pd == OVL_UNKNOWN) d = UD;
    pass = rv[k] && (ra[k][63:1] == a[63:1]);
    rv[k] = 1'b0;
    if (n == 5'd31 && sp[3:0] != 4'h0) begin e.ab_sp = 1'b1; return; end
    if (pass && a[0]) begin e.ab_al = 1'b1; return; end
    e.rf_we = 1'b1;
    e.waddr = s;
    if (pass) begin
      e.mem_we = 1'b1; e.addr = a; e.wdata = d; e.status = 32'd0;
    end else begin
      e.status = 32'd1;
    end
  endtask

  task automatic reserve(input logic [63:0] a);
    @(negedge clk);
    ldx = 1'b1; ldx_addr = a;
    @(negedge clk);
    ldx = 1'b0;
    for (int k = 0; k < 2; k++) begin rv[k] = 1'b1; ra[k] = a; end
  endtask

  task automatic do_op(input logic [31:0] w, input int stall, input string tag);
    obs_t ea, eb;
    int   cnt;
    logic got;
    predict(0, w, ea);
    predict(1, w, eb);
    @(negedge clk);
    pend = (stall == 0);
    insn = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    got = 1'b0;
    while (!got && cnt < 40) begin
      @(negedge clk);
      cnt++;
      if (cnt == stall) pend = 1'b1;
      if (done_a) got = 1'b1;
    end
    chk(128'(cnt), 128'(2 + stall), {tag, " R11 latency"});
    chk(128'(done_b), 128'd1, {tag, " R11 done copy b"});
    chk(128'(act_a), 128'(ea), {tag, " copy a"});
    chk(128'(act_b), 128'(eb), {tag, " copy b"});
    pend = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) regs[i] = 64'h0;
    rv[0] = 1'b0; rv[1] = 1'b0; ra[0] = '0; ra[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(128'({done_a, busy_a, we_a, rwe_a, ud_a, done_b, busy_b}), 128'd0, "R11 reset state");

    regs[1] = 64'h2000; regs[2] = 64'h1234_ABCD; regs[4] = 64'h2000;
    reserve(64'h2000);
    do_op(mk(5'd3, 5'd1, 5'd2), 0, "R2 R3 pass");
    do_op(mk(5'd3, 5'd1, 5'd2), 0, "R5 R4 cleared fails");
    reserve(64'h2001);
    do_op(mk(5'd3, 5'd1, 5'd2), 0, "R3 bit0 ignored");
    reserve(64'h2002);
    do_op(mk(5'd3, 5'd1, 5'd2), 0, "R4 other halfword");
    regs[1] = 64'h3001;
    reserve(64'h3000);
    do_op(mk(5'd3, 5'd1, 5'd2), 0, "R7 R8 align abort");
    do_op(mk(5'd3, 5'd1, 5'd2), 0, "R7 odd no reservation");
    regs[1] = 64'h2000;
    reserve(64'h2000);
    do_op(mk(5'd3, 5'd1, 5'd2) ^ 32'h4000_0000, 0, "R1 bad opcode");
    do_op(mk(5'd3, 5'd1, 5'd2) & ~32'h0000_8000, 0, "R1 bit15 clear");
    do_op(mk(5'd3, 5'd1, 5'd2) & ~32'h0000_7C00, 0, "R1 bits14to10 ignored");
    sp = 64'h4000;
    reserve(64'h4000);
    do_op(mk(5'd3, 5'd31, 5'd2), 0, "R6 stack base");
    sp = 64'h4008;
    reserve(64'h4008);
    do_op(mk(5'd3, 5'd31, 5'd2), 0, "R6 R8 stack misaligned");
    reserve(64'h2000);
    do_op(mk(5'd2, 5'd1, 5'd2), 0, "R9 data overlap");
    do_op(mk(5'd3, 5'd1, 5'd2), 0, "R5 R9 nop keeps reservation");
    reserve(64'h5000);
    do_op(mk(5'd4, 5'd4, 5'd2), 0, "R10 base overlap");
    regs[5] = 64'h5000;
    reserve(64'h5000);
    do_op(mk(5'd5, 5'd5, 5'd5), 0, "R10 data overlap first");
    reserve(64'h2000);
    do_op(mk(5'd3, 5'd1, 5'd2), 5, "R11 ordering stall");
    reserve(64'h2000);
    do_op(mk(5'd31, 5'd1, 5'd2), 0, "R12 status index 31");
    reserve(64'h2000);
    do_op(mk(5'd3, 5'd1, 5'd31), 0, "R3 zero data register");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] rsv;
      logic [4:0]  s, n, t;
      logic [31:0] w;
      rsv = 64'h8000 + 64'($urandom % 16);
      if ($urandom % 3 != 0) reserve(rsv);
      s = ($urandom % 6 == 0) ? 5'd31 : 5'($urandom % 6);
      n = ($urandom % 6 == 0) ? 5'd31 : 5'($urandom % 6);
      t = ($urandom % 6 == 0) ? 5'd31 : 5'($urandom % 6);
      for (int r = 0; r < 6; r++) begin
        case ($urandom % 4)
          0: regs[r] = rsv;
          1: regs[r] = rsv ^ 64'h1;
          2: regs[r] = rsv + 64'h2;
          default: regs[r] = {32'h0, $urandom};
        endcase
      end
      sp = ($urandom % 2 != 0) ? {rsv[63:4], 4'h0} : rsv;
      w = mk(s, n, t);
      if ($urandom % 10 == 0) w = w ^ (32'h1 << ($urandom % 32));
      do_op(w, int'($urandom % 3), "R3 R4 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule